// File: doc/BRIEF.md
# Programmable Stream Delay Buffer

This block holds back a word stream by a number of clock cycles chosen at run time. It lets a vector pipeline fetch one operand stream early, or store a result stream late, so that two streams never hit the same memory bank in the same cycle. It accepts one word per cycle and returns one word per cycle. There is no backpressure.

The delay is loaded with a start strobe. From that point a write counter begins at zero and a read counter begins at minus the delay. Both counters step once per cycle through a circular store. While the read counter is negative, nothing valid leaves the block. A delay of zero skips the store: the input goes straight to the output in the same cycle. A delay the store cannot hold is cut down to the largest legal value, and an error output is raised.

Top module: `stream_delay_line`

## Requirements
- R1: A cycle with `start_i` high loads a new stream. The first cycle after that start edge is stream cycle 0. The input word in stream cycle k is element k. The start cycle's own input is not part of the stream.
- R2: For a delay d with 1 ≤ d ≤ DEPTH-1, element k appears on `data_o` in stream cycle k+d. In that cycle `valid_o` equals the `valid_i` that element k carried.
- R3: For a delay d ≥ 1, `valid_o` is 0 in stream cycles 0 to d-1.
- R4: From reset until the first start, `valid_o` is 0 and `err_o` is 0, whatever the inputs are.
- R5: With a delay of 0, `valid_o` equals `valid_i` in the same cycle. When `valid_i` is 1, `data_o` equals `data_i` in that same cycle.
- R6: A requested delay of DEPTH or more is clamped to DEPTH-1. In that case `err_o` is 1 from the cycle after the start until a start with an in-range delay.
- R7: `delay_i` is sampled only in a start cycle. Changing it at any other time has no effect on the output timing.
- R8: Input slots with `valid_i` = 0 come out as slots with `valid_o` = 0, d cycles later. Timing stays correct for streams far longer than DEPTH.
- R9: A start in the middle of a stream drops all words still held. No word stored before the restart ever appears after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads the delay and restarts the counters |
| delay_i | input | DLY_W | Requested delay in cycles, sampled on start |
| valid_i | input | 1 | Input word qualifier |
| data_i | input | DATA_W | Input word |
| valid_o | output | 1 | Output word qualifier |
| data_o | output | DATA_W | Delayed word |
| err_o | output | 1 | The last requested delay was clamped |

## Verification
The assertions assume that `start_i` is a single-cycle strobe. They also assume that `delay_i` is known in every start cycle. The stimulus only raises `start_i` for one cycle at a time and always sets `delay_i` before it does so. Between starts, the bench drives a changing `delay_i` to show that it is ignored. Delays tried are 0, 1, 3, DEPTH-1 and a value beyond DEPTH. Streams longer than the store are run so that the counters wrap, and one restart is made with words still held in the store.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  // circular step on the non-negative range, plain increment while negative
  function automatic int ptr_inc(int p, int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/sdl_ctrl.sv
module sdl_ctrl #(
  parameter int DEPTH = 16,
  parameter int DLY_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             rd_ok_o,
  output logic             active_o,
  output logic             zero_o,
  output logic             err_o
);
  logic signed [PTR_W-1:0] wr_ptr, rd_ptr;
  logic active_q, zero_q, err_q;
  logic over;
  int   dly_int;

  always_comb begin
    over    = 32'(delay_i) >= DEPTH;
    dly_int = over ? DEPTH - 1 : int'(delay_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      active_q <= 1'b0;
      zero_q   <= 1'b0;
      err_q    <= 1'b0;
    end else if (start_i) begin
      wr_ptr   <= '0;
      rd_ptr   <= PTR_W'(-dly_int);
      active_q <= 1'b1;
      zero_q   <= (dly_int == 0);
      err_q    <= over;
    end else if (active_q) begin
      wr_ptr <= PTR_W'(sdl_pkg::ptr_inc(int'(wr_ptr), DEPTH));
      rd_ptr <= PTR_W'(sdl_pkg::ptr_inc(int'(rd_ptr), DEPTH));
    end
  end

  assign wr_idx_o = wr_ptr[IDX_W-1:0];
  assign rd_idx_o = rd_ptr[IDX_W-1:0];
  assign rd_ok_o  = active_q & ~rd_ptr[PTR_W-1];
  assign active_o = active_q;
  assign zero_o   = zero_q;
  assign err_o    = err_q;

  assert_wr_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> wr_ptr == '0);
  assert_rd_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && 32'(delay_i) < DEPTH) |=> int'(rd_ptr) == -int'($past(delay_i)));
  assert_clamp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && 32'(delay_i) >= DEPTH) |=> (err_o && int'(rd_ptr) == -(DEPTH - 1)));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(zero_o) && $stable(err_o)));
  assert_rd_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rd_ptr) > -DEPTH);
endmodule

// File: rtl/sdl_store.sv
module sdl_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W:0] cell_q [DEPTH];

  // one write and one read of another cell in the same cycle
  always_ff @(posedge clk_i) begin
    if (we_i) cell_q[wr_idx_i] <= {wr_valid_i, wr_data_i};
  end

  assign rd_valid_o = cell_q[rd_idx_i][DATA_W];
  assign rd_data_o  = cell_q[rd_idx_i][DATA_W-1:0];
endmodule

// File: rtl/stream_delay_line.sv
module stream_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int DLY_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              rd_ok, active, zero;
  logic              mem_valid;
  logic [DATA_W-1:0] mem_data;

  sdl_ctrl #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .delay_i,
    .wr_idx_o(wr_idx), .rd_idx_o(rd_idx), .rd_ok_o(rd_ok),
    .active_o(active), .zero_o(zero), .err_o
  );

  sdl_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i,
    .we_i(active & ~start_i),
    .wr_idx_i(wr_idx), .wr_valid_i(valid_i), .wr_data_i(data_i),
    .rd_idx_i(rd_idx), .rd_valid_o(mem_valid), .rd_data_o(mem_data)
  );

  // zero delay bypasses the store
  assign valid_o = active & (zero ? valid_i : (rd_ok & mem_valid));
  assign data_o  = zero ? data_i : mem_data;

  assert_no_early_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !zero && !rd_ok) |-> !valid_o);
  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (!valid_o && !err_o));
  assert_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && zero) |-> (valid_o == valid_i && (!valid_i || data_o == data_i)));
endmodule

// File: tb/stream_delay_line_tb.sv
module stream_delay_line_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int DLY_W  = 8;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, valid_i = 0;
  logic [DLY_W-1:0]  delay_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic valid_o, err_o;
  logic [DATA_W-1:0] data_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit m_active = 0, m_err = 0;
  int m_d = 0, m_k = 0;
  logic [DATA_W:0] hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DLY_W(DLY_W)) u_dut (
    .clk_i(clk), .rst_ni, .start_i, .delay_i, .valid_i, .data_i,
    .valid_o, .data_o, .err_o
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic step(input bit st, input int dly, input bit v,
                      input logic [DATA_W-1:0] d, input string ph);
    bit ev; logic [DATA_W-1:0] ed; string cls;
    @(negedge clk);
    start_i = st; delay_i = DLY_W'(dly); valid_i = v; data_i = d;
    #1;
    ed = 'x;
    if (!m_active) begin ev = 0; cls = "R4"; end
    else if (m_d == 0) begin ev = v; ed = d; cls = "R5"; end
    else if (m_k < m_d) begin ev = 0; cls = "R3"; end
    else begin ev = hist[m_k - m_d][DATA_W]; ed = hist[m_k - m_d][DATA_W-1:0]; cls = "R2"; end
    checks++;
    if (valid_o !== ev || (ev && data_o !== ed)) begin
      errors++;
      $display("FAIL %s/%s: valid_o=%0b data_o=%0h expected valid=%0b data=%0h",
               ph, cls, valid_o, data_o, ev, ed);
    end
    checks++;
    if (err_o !== m_err) begin
      errors++;
      $display("FAIL %s/R6: err_o=%0b expected %0b", ph, err_o, m_err);
    end
    // model reacts to the coming edge
    if (st) begin
      m_active = 1; m_k = 0; hist.delete();
      m_err = (dly >= DEPTH);
      m_d = (dly >= DEPTH) ? DEPTH - 1 : dly;
    end else if (m_active) begin
      hist.push_back({v, d});
      m_k++;
    end
  endtask

  task automatic run(input int n, input int seed, input int vmod, input string ph,
                     input int noise);
    for (int i = 0; i < n; i++)
      step(0, (noise != 0) ? (i * 7) % 5 : 0, (i % vmod) != (vmod - 1),
           DATA_W'(i * 37 + seed), ph);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 3);
    rst_ni = 1;
    run(6, 11, 3, "R4", 1);                  // idle, inputs toggling
    step(1, 3, 0, '0, "R1");
    run(45, 101, 5, "R8", 0);                // gaps, wraps past DEPTH
    step(1, 0, 0, '0, "R5");
    run(12, 303, 4, "R5", 0);
    step(1, DEPTH - 1, 0, '0, "R2");
    run(40, 505, 6, "R2", 0);
    step(1, 200, 0, '0, "R6");               // clamp
    run(40, 707, 7, "R7", 1);                // delay_i changes mid-stream
    step(1, 4, 0, '0, "R6");
    run(8, 909, 100, "R9", 0);
    step(1, 5, 0, '0, "R9");                 // restart with words held
    run(30, 1111, 3, "R9", 0);
    step(1, 1, 0, '0, "R2");
    run(20, 1313, 100, "R2", 0);
    finish_run();
  end
endmodule